// File: doc/BRIEF.md
# Nested-Translation TLB Invalidation Engine

This block is the tag store of a small, fully associative translation cache. Each entry carries a valid flag, a 16-bit address-space tag, a 16-bit virtual-machine tag and a page address. Entries are written through a fill port, and a lookup port reports a hit and the index of the lowest matching slot. A command port takes invalidation requests. Every slot is compared against a request in parallel in one cycle. The block then drops the selected entries and returns a one-cycle completion pulse with an error flag.

Two configuration inputs state whether first-stage and second-stage translation are available. The tag value of all ones has a reserved meaning. In the VM tag it marks an entry that belongs to the first stage only. In the address-space tag it marks an entry that belongs to the second stage only. When second-stage translation is present, the first-stage invalidate commands are limited to one VM. A first-stage bulk invalidate then leaves that VM's second-stage-only entries in place.

Top module: `tlbinv_engine`

## Requirements
- R1: After reset, every slot is invalid, no lookup hits, and `done` and `err` are low.
- R2: A per-address-space invalidate (opcode 3'd1) or a first-stage invalidate-all (opcode 3'd2), issued while `cfg_s1_en` is low, returns `err`=1 and leaves every entry unchanged.
- R3: A per-address-space invalidate clears the valid entries whose address-space tag equals `cmd_asid`. Their VM tag must also equal `cmd_vmid` when `cfg_s2_en` is high, and must equal 16'hFFFF when `cfg_s2_en` is low.
- R4: With `cfg_s2_en` high, a first-stage invalidate-all clears only the entries whose VM tag equals `cmd_vmid` and whose address-space tag has bit 15 clear. Entries with address-space tag 16'hFFFF survive.
- R5: With `cfg_s2_en` low, a first-stage invalidate-all clears every entry, whatever its tags.
- R6: A global invalidate (opcode 3'd4) clears every entry in any configuration.
- R7: A VM invalidate (opcode 3'd3) clears every entry whose VM tag equals `cmd_vmid`, second-stage-only entries included.
- R8: `done` is high for exactly the one cycle after the command cycle. `err` is valid in that same cycle and is 0 for accepted commands and 1 for illegal ones.
- R9: Opcodes other than 3'd1 to 3'd4 return `err`=1 and change no entry.
- R10: A lookup result appears in the cycle after the request. When it arrives together with an invalidation, it reflects the entries as they were before that invalidation. When several slots match, it reports the lowest index.
- R11: A fill into a slot in the same cycle that an invalidation clears that slot leaves the slot valid with the new tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_s1_en | input | 1 | First-stage translation available |
| cfg_s2_en | input | 1 | Second-stage translation available |
| cmd_valid | input | 1 | Invalidation command present this cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_asid | input | 16 | Address-space tag of the command |
| cmd_vmid | input | 16 | VM tag of the command |
| fill_valid | input | 1 | Write one slot this cycle |
| fill_idx | input | 3 | Slot to write |
| fill_asid | input | 16 | Address-space tag to store |
| fill_vmid | input | 16 | VM tag to store |
| fill_page | input | 20 | Page address to store |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | 16 | Lookup address-space tag |
| lk_vmid | input | 16 | Lookup VM tag |
| lk_page | input | 20 | Lookup page address |
| lk_hit | output | 1 | Lookup hit, one cycle after the request |
| lk_idx | output | 3 | Lowest matching slot, valid when lk_hit |
| done | output | 1 | Command completion pulse |
| err | output | 1 | Illegal-command flag, valid with done |

## Verification
The assertions assume that every input is 0 or 1 on each active clock edge once reset is released. They also assume that `fill_idx` addresses an existing slot and that the configuration inputs do not change in the cycle a command is sampled. The bench drives all inputs on the falling edge. It changes the configuration only in idle cycles and uses only slot indices below the entry count. It mixes fills, commands and lookups in the same cycle, so that the same-cycle ordering rules are exercised without leaving those assumptions.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;

    localparam int TAG_W = 16;

    typedef logic [TAG_W-1:0] tag_t;

    // All-ones tag: in the VM field it marks a first-stage-only entry,
    // in the address-space field a second-stage-only entry.
    localparam tag_t TAG_RESERVED = '1;

    typedef enum logic [2:0] {
        OP_INV_ASID   = 3'd1,
        OP_INV_S1     = 3'd2,
        OP_INV_VM     = 3'd3,
        OP_INV_GLOBAL = 3'd4
    } inv_op_e;

    // Selection rule handed from the decoder to every slot comparator.
    typedef struct packed {
        logic active;       // a legal command is present
        logic wipe_all;     // ignore the tags
        logic chk_asid;     // address-space tag must match
        logic chk_vmid;     // VM tag must match
        logic need_s1_asid; // address-space tag must be non-negative
        tag_t asid;
        tag_t vmid;
    } sel_t;

endpackage

// File: rtl/tlbinv_decode.sv
module tlbinv_decode
    import tlbinv_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  tag_t       cmd_asid,
    input  tag_t       cmd_vmid,
    input  logic       s1_ok,
    input  logic       s2_ok,
    output logic       legal,
    output sel_t       sel
);

    always_comb begin
        sel   = '0;
        legal = 1'b0;
        case (inv_op_e'(cmd_op))
            OP_INV_ASID: begin
                if (s1_ok) begin
                    legal        = 1'b1;
                    sel.chk_asid = 1'b1;
                    sel.asid     = cmd_asid;
                    sel.chk_vmid = 1'b1;
                    sel.vmid     = s2_ok ? cmd_vmid : TAG_RESERVED;
                end
            end
            OP_INV_S1: begin
                if (s1_ok) begin
                    legal = 1'b1;
                    if (s2_ok) begin
                        sel.chk_vmid     = 1'b1;
                        sel.vmid         = cmd_vmid;
                        sel.need_s1_asid = 1'b1;
                    end else begin
                        sel.wipe_all = 1'b1;
                    end
                end
            end
            OP_INV_VM: begin
                legal        = 1'b1;
                sel.chk_vmid = 1'b1;
                sel.vmid     = cmd_vmid;
            end
            OP_INV_GLOBAL: begin
                legal        = 1'b1;
                sel.wipe_all = 1'b1;
            end
            default: begin
                legal = 1'b0;
            end
        endcase
        sel.active = cmd_valid & legal;
    end

endmodule

// File: rtl/tlbinv_match.sv
module tlbinv_match
    import tlbinv_pkg::*;
(
    input  logic ent_vld,
    input  tag_t ent_asid,
    input  tag_t ent_vmid,
    input  sel_t sel,
    output logic kill
);

    logic asid_ok;
    logic vmid_ok;
    logic stage_ok;

    always_comb begin
        asid_ok  = !sel.chk_asid || (ent_asid == sel.asid);
        vmid_ok  = !sel.chk_vmid || (ent_vmid == sel.vmid);
        stage_ok = !sel.need_s1_asid || !ent_asid[TAG_W-1];
        kill     = sel.active && ent_vld &&
                   (sel.wipe_all || (asid_ok && vmid_ok && stage_ok));
    end

endmodule

// File: rtl/tlbinv_lookup.sv
module tlbinv_lookup
    import tlbinv_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PAGE_W  = 20,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]             vld,
    input  logic [ENTRIES-1:0][TAG_W-1:0]  asid,
    input  logic [ENTRIES-1:0][TAG_W-1:0]  vmid,
    input  logic [ENTRIES-1:0][PAGE_W-1:0] page,
    input  tag_t                           q_asid,
    input  tag_t                           q_vmid,
    input  logic [PAGE_W-1:0]              q_page,
    output logic                           hit,
    output logic [IDX_W-1:0]               idx
);

    logic [ENTRIES-1:0] hitv;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hitv[g] = vld[g] && (asid[g] == q_asid) &&
                         (vmid[g] == q_vmid) && (page[g] == q_page);
    end

    // Scan downwards so the lowest matching slot is the one left.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hitv[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlbinv_engine.sv
module tlbinv_engine
    import tlbinv_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PAGE_W  = 20,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_s1_en,
    input  logic              cfg_s2_en,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [TAG_W-1:0]  cmd_asid,
    input  logic [TAG_W-1:0]  cmd_vmid,
    input  logic              fill_valid,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_asid,
    input  logic [TAG_W-1:0]  fill_vmid,
    input  logic [PAGE_W-1:0] fill_page,
    input  logic              lk_valid,
    input  logic [TAG_W-1:0]  lk_asid,
    input  logic [TAG_W-1:0]  lk_vmid,
    input  logic [PAGE_W-1:0] lk_page,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic              done,
    output logic              err
);

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][TAG_W-1:0]  asid;
        logic [ENTRIES-1:0][TAG_W-1:0]  vmid;
        logic [ENTRIES-1:0][PAGE_W-1:0] page;
        logic                           done;
        logic                           err;
        logic                           hit;
        logic [IDX_W-1:0]               idx;
    } state_t;

    state_t st_d, st_q;

    sel_t               sel;
    logic               cmd_legal;
    logic [ENTRIES-1:0] kill;
    logic               lu_hit;
    logic [IDX_W-1:0]   lu_idx;

    tlbinv_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_asid  (cmd_asid),
        .cmd_vmid  (cmd_vmid),
        .s1_ok     (cfg_s1_en),
        .s2_ok     (cfg_s2_en),
        .legal     (cmd_legal),
        .sel       (sel)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        tlbinv_match u_match (
            .ent_vld  (st_q.vld[g]),
            .ent_asid (st_q.asid[g]),
            .ent_vmid (st_q.vmid[g]),
            .sel      (sel),
            .kill     (kill[g])
        );
    end

    // Lookup reads the registered state, so it sees pre-invalidation tags.
    tlbinv_lookup #(
        .ENTRIES (ENTRIES),
        .PAGE_W  (PAGE_W)
    ) u_lookup (
        .vld    (st_q.vld),
        .asid   (st_q.asid),
        .vmid   (st_q.vmid),
        .page   (st_q.page),
        .q_asid (lk_asid),
        .q_vmid (lk_vmid),
        .q_page (lk_page),
        .hit    (lu_hit),
        .idx    (lu_idx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = cmd_valid;
        st_d.err  = cmd_valid && !cmd_legal;
        st_d.hit  = lk_valid && lu_hit;
        st_d.idx  = (lk_valid && lu_hit) ? lu_idx : '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (kill[i]) begin
                st_d.vld[i] = 1'b0;
            end
            // Fill is applied after the clear so it wins on the same slot.
            if (fill_valid && (fill_idx == IDX_W'(i))) begin
                st_d.vld[i]  = 1'b1;
                st_d.asid[i] = fill_asid;
                st_d.vmid[i] = fill_vmid;
                st_d.page[i] = fill_page;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lk_hit = st_q.hit;
    assign lk_idx = st_q.idx;
    assign done   = st_q.done;
    assign err    = st_q.err;

    AST_NO_S1_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cfg_s1_en && (cmd_op == OP_INV_ASID || cmd_op == OP_INV_S1))
        |=> (done && err)) else $error("first-stage command not flagged"); // R2

    AST_ILLEGAL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_legal && !fill_valid) |=> (st_q.vld == $past(st_q.vld)))
        else $error("illegal command changed entries"); // R9

    AST_GLOBAL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_INV_GLOBAL && !fill_valid) |=> (st_q.vld == '0))
        else $error("global invalidate left entries"); // R6

    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(cmd_valid)) else $error("done without command"); // R8

    AST_HIT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> $past(lk_valid)) else $error("hit without lookup"); // R10

    AST_FILL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> st_q.vld[$past(fill_idx)]) else $error("fill lost"); // R11

    for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
        AST_S2ONLY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && cmd_op == OP_INV_S1 && cfg_s1_en && cfg_s2_en &&
             st_q.vld[g] && st_q.asid[g] == TAG_RESERVED) |=> st_q.vld[g])
            else $error("second-stage-only entry cleared"); // R4
    end

endmodule

// File: tb/sim_tlbinv_engine.sv
`timescale 1ns/1ps
module sim_tlbinv_engine;

    localparam int ENT = 8;
    localparam int PW  = 20;
    localparam int IW  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_s1_en = 1'b1;
    logic          cfg_s2_en = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [15:0]   cmd_asid = '0;
    logic [15:0]   cmd_vmid = '0;
    logic          fill_valid = 1'b0;
    logic [IW-1:0] fill_idx = '0;
    logic [15:0]   fill_asid = '0;
    logic [15:0]   fill_vmid = '0;
    logic [PW-1:0] fill_page = '0;
    logic          lk_valid = 1'b0;
    logic [15:0]   lk_asid = '0;
    logic [15:0]   lk_vmid = '0;
    logic [PW-1:0] lk_page = '0;
    logic          lk_hit;
    logic [IW-1:0] lk_idx;
    logic          done;
    logic          err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    bit            m_v [ENT];
    logic [15:0]   m_a [ENT];
    logic [15:0]   m_m [ENT];
    logic [PW-1:0] m_p [ENT];

    always #10 clk = ~clk;

    tlbinv_engine u0 (
        .clk(clk), .rst_n(rst_n), .cfg_s1_en(cfg_s1_en), .cfg_s2_en(cfg_s2_en),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_asid(cmd_asid), .cmd_vmid(cmd_vmid),
        .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_asid(fill_asid),
        .fill_vmid(fill_vmid), .fill_page(fill_page), .lk_valid(lk_valid),
        .lk_asid(lk_asid), .lk_vmid(lk_vmid), .lk_page(lk_page),
        .lk_hit(lk_hit), .lk_idx(lk_idx), .done(done), .err(err)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit model_legal();
        if (cmd_op == 3'd3 || cmd_op == 3'd4) return 1'b1;
        if ((cmd_op == 3'd1 || cmd_op == 3'd2) && cfg_s1_en) return 1'b1;
        return 1'b0;
    endfunction

    // Which entries the spec says a command removes.
    function automatic bit model_kill(input int i);
        if (!cmd_valid || !m_v[i] || !model_legal()) return 1'b0;
        case (cmd_op)
            3'd1: return (m_a[i] == cmd_asid) &&
                         (m_m[i] == (cfg_s2_en ? cmd_vmid : 16'hFFFF));
            3'd2: return cfg_s2_en ? ((m_m[i] == cmd_vmid) && (m_a[i] < 16'h8000)) : 1'b1;
            3'd3: return m_m[i] == cmd_vmid;
            default: return 1'b1;
        endcase
    endfunction

    task automatic step(input string tag);
        bit e_done, e_err, e_hit;
        int e_idx;
        bit kl [ENT];
        e_done = cmd_valid;
        e_err  = cmd_valid && !model_legal();
        e_hit  = 1'b0;
        e_idx  = 0;
        if (lk_valid) begin
            for (int i = ENT - 1; i >= 0; i--) begin
                if (m_v[i] && m_a[i] == lk_asid && m_m[i] == lk_vmid && m_p[i] == lk_page) begin
                    e_hit = 1'b1;
                    e_idx = i;
                end
            end
        end
        for (int i = 0; i < ENT; i++) kl[i] = model_kill(i);
        @(posedge clk);
        for (int i = 0; i < ENT; i++) if (kl[i]) m_v[i] = 1'b0;
        if (fill_valid) begin
            m_v[fill_idx] = 1'b1;
            m_a[fill_idx] = fill_asid;
            m_m[fill_idx] = fill_vmid;
            m_p[fill_idx] = fill_page;
        end
        @(negedge clk);
        check(tag, "done", int'(done), int'(e_done));
        check(tag, "err", int'(err), int'(e_err));
        check(tag, "lk_hit", int'(lk_hit), int'(e_hit));
        if (e_hit) check(tag, "lk_idx", int'(lk_idx), e_idx);
        cmd_valid  = 1'b0;
        fill_valid = 1'b0;
        lk_valid   = 1'b0;
    endtask

    task automatic set_fill(input int idx, input logic [15:0] a, input logic [15:0] m, input int p);
        fill_valid = 1'b1;
        fill_idx   = IW'(idx);
        fill_asid  = a;
        fill_vmid  = m;
        fill_page  = PW'(p);
    endtask

    task automatic set_cmd(input logic [2:0] op, input logic [15:0] a, input logic [15:0] m);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_asid  = a;
        cmd_vmid  = m;
    endtask

    task automatic set_look(input logic [15:0] a, input logic [15:0] m, input int p);
        lk_valid = 1'b1;
        lk_asid  = a;
        lk_vmid  = m;
        lk_page  = PW'(p);
    endtask

    task automatic fill(input int idx, input logic [15:0] a, input logic [15:0] m, input int p);
        set_fill(idx, a, m, p);
        step("R8 fill");
    endtask

    task automatic cmd(input logic [2:0] op, input logic [15:0] a, input logic [15:0] m,
                       input bit exp_err, input string tag);
        set_cmd(op, a, m);
        step(tag);
        check(tag, "err code", int'(err), int'(exp_err));
    endtask

    task automatic look(input logic [15:0] a, input logic [15:0] m, input int p,
                        input bit exp_hit, input int exp_idx, input string tag);
        set_look(a, m, p);
        step(tag);
        check(tag, "hit", int'(lk_hit), int'(exp_hit));
        if (exp_hit) check(tag, "idx", int'(lk_idx), exp_idx);
    endtask

    // Standard population: slot 2 second-stage only, slot 4 first-stage only.
    task automatic populate();
        fill(0, 16'd5, 16'd1, 100);
        fill(1, 16'd5, 16'd2, 101);
        fill(2, 16'hFFFF, 16'd1, 102);
        fill(3, 16'd7, 16'd1, 103);
        fill(4, 16'd5, 16'hFFFF, 104);
    endtask

    initial begin
        for (int i = 0; i < ENT; i++) begin
            m_v[i] = 1'b0; m_a[i] = '0; m_m[i] = '0; m_p[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        check("R1", "done after reset", int'(done), 0);
        check("R1", "err after reset", int'(err), 0);
        look(16'd0, 16'd0, 0, 1'b0, 0, "R1 empty lookup");

        populate();
        cmd(3'd1, 16'd5, 16'd1, 1'b0, "R3 asid s2");
        look(16'd5, 16'd1, 100, 1'b0, 0, "R3 asid s2 cleared");
        look(16'd5, 16'd2, 101, 1'b1, 1, "R3 other vm kept");
        look(16'd5, 16'hFFFF, 104, 1'b1, 4, "R3 s1-only kept");

        fill(0, 16'd5, 16'd1, 100);
        cfg_s2_en = 1'b0;
        cmd(3'd1, 16'd5, 16'd1, 1'b0, "R3 asid no s2");
        look(16'd5, 16'hFFFF, 104, 1'b0, 0, "R3 reserved vm cleared");
        look(16'd5, 16'd1, 100, 1'b1, 0, "R3 tagged vm kept");

        cfg_s2_en = 1'b1;
        fill(4, 16'd5, 16'hFFFF, 104);
        cmd(3'd2, 16'd0, 16'd1, 1'b0, "R4 s1 all");
        look(16'hFFFF, 16'd1, 102, 1'b1, 2, "R4 s2-only survives");
        look(16'd5, 16'd1, 100, 1'b0, 0, "R4 slot0 cleared");
        look(16'd7, 16'd1, 103, 1'b0, 0, "R4 slot3 cleared");
        look(16'd5, 16'd2, 101, 1'b1, 1, "R4 other vm kept");

        cmd(3'd3, 16'd0, 16'd1, 1'b0, "R7 vm inv");
        look(16'hFFFF, 16'd1, 102, 1'b0, 0, "R7 s2-only cleared");
        look(16'd5, 16'd2, 101, 1'b1, 1, "R7 other vm kept");

        cfg_s1_en = 1'b0;
        cmd(3'd1, 16'd5, 16'd2, 1'b1, "R2 asid no s1");
        look(16'd5, 16'd2, 101, 1'b1, 1, "R2 entry kept");
        cmd(3'd2, 16'd0, 16'd2, 1'b1, "R2 s1all no s1");
        look(16'd5, 16'd2, 101, 1'b1, 1, "R2 entry kept after s1all");
        cfg_s1_en = 1'b1;

        cmd(3'd0, 16'd5, 16'd2, 1'b1, "R9 opcode 0");
        cmd(3'd7, 16'd5, 16'd2, 1'b1, "R9 opcode 7");
        look(16'd5, 16'd2, 101, 1'b1, 1, "R9 entry kept");

        check("R8", "done falls", int'(done), 0);

        cfg_s2_en = 1'b0;
        populate();
        cmd(3'd2, 16'd0, 16'd9, 1'b0, "R5 s1all as global");
        look(16'hFFFF, 16'd1, 102, 1'b0, 0, "R5 s2-only cleared");
        look(16'd5, 16'd2, 101, 1'b0, 0, "R5 other vm cleared");

        cfg_s2_en = 1'b1;
        populate();
        cmd(3'd4, 16'd0, 16'd0, 1'b0, "R6 global");
        look(16'd5, 16'hFFFF, 104, 1'b0, 0, "R6 cleared");
        look(16'hFFFF, 16'd1, 102, 1'b0, 0, "R6 cleared s2-only");

        fill(3, 16'd8, 16'd3, 300);
        fill(1, 16'd8, 16'd3, 300);
        look(16'd8, 16'd3, 300, 1'b1, 1, "R10 lowest index");
        set_look(16'd8, 16'd3, 300);
        set_cmd(3'd4, 16'd0, 16'd0);
        step("R10 same cycle");
        check("R10", "pre-invalidate view", int'(lk_hit), 1);
        look(16'd8, 16'd3, 300, 1'b0, 0, "R10 after invalidate");

        fill(2, 16'd4, 16'd4, 400);
        set_fill(2, 16'd6, 16'd6, 600);
        set_cmd(3'd4, 16'd0, 16'd0);
        step("R11 fill vs clear");
        look(16'd6, 16'd6, 600, 1'b1, 2, "R11 fill wins");
        look(16'd4, 16'd4, 400, 1'b0, 0, "R11 old tags gone");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

endmodule